// File: doc/BRIEF.md
# Prescaled Timer with Match and Capture

This block is a general-purpose timer. A free-running prescale counter divides the peripheral clock, and every time it wraps, the timer counter advances by one. Both counter widths are set by a parameter. Several compare channels watch the timer counter. Each channel can raise an interrupt, restart the count from zero, or halt the timer when the count reaches the channel's value. Each compare channel also drives an output pin whose level is cleared, set or toggled on a hit.

Several capture pins are synchronised into the clock domain. On a chosen edge, each one copies the timer counter into a channel register and can raise an interrupt. Software controls the block through a simple single-cycle register bus. Reads are combinational on the address. Writes take effect at the clock edge on which the write strobe is high.

Delays are easy to measure. Software programs a compare value with the halt action, starts the timer, and then polls the run bit until the hardware clears it.

Top module: `ptmr_top`

## Requirements
- R1: While running and not held, the prescale counter (address 2) increases by one on every clock. On the clock where it equals the prescale value (address 1), it returns to 0 and the timer counter (address 3) increases by one. After M clocks of running from zero with prescale value P, the timer counter reads floor(M/(P+1)) and the prescale counter reads M mod (P+1).
- R2: Control register (address 0): bit 0 is the run bit and bit 1 is the hold bit. While the hold bit is 1, both counters are forced to zero. While both bits are 0, both counters keep their value.
- R3: Compare channel n has its value at address 8+n. It hits on a prescaler wrap while the timer counter equals that value. If the restart flag (bit 3n+1 of address 4) is set, the timer counter goes to 0 on that wrap instead of value+1, which gives a period of (value+1)*(P+1) clocks.
- R4: If the halt flag of channel n (bit 3n+2 of address 4; bit 2 for channel 0) is set, a hit clears the run bit at that same edge. The timer counter stays at the compare value and the prescale counter stays at 0.
- R5: Address 5 bits [3:0] hold the compare output levels, which software can write directly. Bits [5+2n:4+2n] hold the action code of channel n, applied on each hit: 00 keeps the level, 01 drives it to 0, 10 drives it to 1, 11 inverts it. When a hit and a software write fall on the same edge, the hit wins.
- R6: Capture channel n is configured at address 6: bit 3n selects the rising edge and bit 3n+1 selects the falling edge. On a selected edge, the channel loads the timer counter into address 16+n at the third clock edge after the pin changes, because a two-flop synchroniser sits in front of the edge detector. An edge that is not selected leaves that register unchanged.
- R7: The interrupt register (address 7) has one bit per channel. Bits [3:0] are set by compare hits whose interrupt flag (bit 3n of address 4) is set. Bits [7:4] are set by capture events whose interrupt flag (bit 3n+2 of address 6) is set. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a set on the same edge wins over a clear. The irq_o output is high whenever any bit is set.
- R8: After reset, every register reads zero, and irq_o and all compare outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for bus_addr_i |
| cap_i | input | NUM_CAP | Capture pins, asynchronous |
| ext_match_o | output | NUM_MATCH | Compare output levels |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a capture whose expected value is known exactly, despite the synchroniser latency. The bench first runs the timer for a random number of clocks and then clears the run bit, so the count is frozen. It then toggles the pins and compares each capture register with that frozen count. Next, the timer runs again to a new value before the opposite edges are applied, so a wrongly taken edge would show up as a changed register. Compare restart and halt are reached with random compare and prescale values, and each readback is sampled at the exact clock count derived from (value+1)*(P+1).

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    EM_KEEP = 2'b00,
    EM_CLR  = 2'b01,
    EM_SET  = 2'b10,
    EM_TOG  = 2'b11
  } em_act_e;

  localparam int unsigned MC_IRQ   = 0;
  localparam int unsigned MC_RST   = 1;
  localparam int unsigned MC_STOP  = 2;
  localparam int unsigned MC_FLD_W = 3;

  localparam int unsigned CC_RISE  = 0;
  localparam int unsigned CC_FALL  = 1;
  localparam int unsigned CC_IRQ   = 2;
  localparam int unsigned CC_FLD_W = 3;

  localparam int unsigned A_CTRL    = 0;
  localparam int unsigned A_PRE     = 1;
  localparam int unsigned A_PCNT    = 2;
  localparam int unsigned A_TCNT    = 3;
  localparam int unsigned A_MCTL    = 4;
  localparam int unsigned A_EMR     = 5;
  localparam int unsigned A_CCTL    = 6;
  localparam int unsigned A_IRQ     = 7;
  localparam int unsigned A_MR_BASE = 8;
  localparam int unsigned A_CR_BASE = 16;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  // >= keeps the divider sane if software lowers the limit mid-count
  assign tick_o  = run_i && !clear_i && (cnt_q >= limit_i);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else if (run_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_match_ch.sv
module ptmr_match_ch import ptmr_pkg::*; #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] tc_i,
  input  logic [CNT_W-1:0] value_i,
  input  em_act_e          act_i,
  input  logic             lvl_we_i,
  input  logic             lvl_d_i,
  output logic             hit_o,
  output logic             lvl_o
);
  logic lvl_q;

  assign hit_o = tick_i && (tc_i == value_i);
  assign lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
    end else if (hit_o && act_i != EM_KEEP) begin
      unique case (act_i)
        EM_CLR:  lvl_q <= 1'b0;
        EM_SET:  lvl_q <= 1'b1;
        EM_TOG:  lvl_q <= ~lvl_q;
        default: lvl_q <= lvl_q;
      endcase
    end else if (lvl_we_i) begin
      lvl_q <= lvl_d_i;
    end
  end
endmodule

// File: rtl/ptmr_capture_ch.sv
module ptmr_capture_ch #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             rise_en_i,
  input  logic             fall_en_i,
  input  logic [CNT_W-1:0] tc_i,
  output logic             evt_o,
  output logic [CNT_W-1:0] value_o
);
  localparam int unsigned CHAIN_W = SYNC_N + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CNT_W-1:0]   val_q;
  logic               cur, prev;

  assign cur   = chain_q[SYNC_N-1];
  assign prev  = chain_q[SYNC_N];
  assign evt_o = (rise_en_i && cur && !prev) || (fall_en_i && !cur && prev);
  assign value_o = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      val_q   <= '0;
    end else begin
      chain_q <= {chain_q[CHAIN_W-2:0], pin_i};
      if (evt_o) val_q <= tc_i;
    end
  end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top import ptmr_pkg::*; #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_MATCH = 4,
  parameter int unsigned NUM_CAP   = 4,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [CNT_W-1:0]     bus_wdata_i,
  output logic [CNT_W-1:0]     bus_rdata_o,
  input  logic [NUM_CAP-1:0]   cap_i,
  output logic [NUM_MATCH-1:0] ext_match_o,
  output logic                 irq_o
);
  localparam int unsigned IRQ_W  = NUM_MATCH + NUM_CAP;
  localparam int unsigned MCTL_W = MC_FLD_W * NUM_MATCH;
  localparam int unsigned CCTL_W = CC_FLD_W * NUM_CAP;
  localparam int unsigned ACT_W  = 2 * NUM_MATCH;

  logic                 en_q, hold_q;
  logic [CNT_W-1:0]     pre_q, tc_q, pc;
  logic [MCTL_W-1:0]    mctl_q;
  logic [CCTL_W-1:0]    cctl_q;
  logic [ACT_W-1:0]     act_q;
  logic [IRQ_W-1:0]     irq_q, irq_set;
  logic [CNT_W-1:0]     mr_q [NUM_MATCH];
  logic [CNT_W-1:0]     cr   [NUM_CAP];
  logic [NUM_MATCH-1:0] hit, rst_sel, stop_sel, mirq_sel;
  logic [NUM_CAP-1:0]   cap_evt, cirq_sel;
  logic                 tick, rst_req, stop_req;
  logic                 wr_ctrl, wr_pre, wr_mctl, wr_emr, wr_cctl, wr_irq;

  assign wr_ctrl = bus_we_i && bus_addr_i == ADDR_W'(A_CTRL);
  assign wr_pre  = bus_we_i && bus_addr_i == ADDR_W'(A_PRE);
  assign wr_mctl = bus_we_i && bus_addr_i == ADDR_W'(A_MCTL);
  assign wr_emr  = bus_we_i && bus_addr_i == ADDR_W'(A_EMR);
  assign wr_cctl = bus_we_i && bus_addr_i == ADDR_W'(A_CCTL);
  assign wr_irq  = bus_we_i && bus_addr_i == ADDR_W'(A_IRQ);

  ptmr_prescale #(.CNT_W(CNT_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (en_q),
    .clear_i (hold_q),
    .limit_i (pre_q),
    .count_o (pc),
    .tick_o  (tick)
  );

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    assign mirq_sel[i] = mctl_q[MC_FLD_W*i + MC_IRQ];
    assign rst_sel[i]  = mctl_q[MC_FLD_W*i + MC_RST];
    assign stop_sel[i] = mctl_q[MC_FLD_W*i + MC_STOP];

    ptmr_match_ch #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .tc_i     (tc_q),
      .value_i  (mr_q[i]),
      .act_i    (em_act_e'(act_q[2*i +: 2])),
      .lvl_we_i (wr_emr),
      .lvl_d_i  (bus_wdata_i[i]),
      .hit_o    (hit[i]),
      .lvl_o    (ext_match_o[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mr_q[i] <= '0;
      else if (bus_we_i && bus_addr_i == ADDR_W'(A_MR_BASE + i)) mr_q[i] <= bus_wdata_i;
    end
  end

  for (genvar i = 0; i < NUM_CAP; i++) begin : g_cap
    assign cirq_sel[i] = cctl_q[CC_FLD_W*i + CC_IRQ];

    ptmr_capture_ch #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (cap_i[i]),
      .rise_en_i (cctl_q[CC_FLD_W*i + CC_RISE]),
      .fall_en_i (cctl_q[CC_FLD_W*i + CC_FALL]),
      .tc_i      (tc_q),
      .evt_o     (cap_evt[i]),
      .value_o   (cr[i])
    );
  end

  assign rst_req  = |(hit & rst_sel);
  assign stop_req = |(hit & stop_sel);
  assign irq_set  = {cap_evt & cirq_sel, hit & mirq_sel};
  assign irq_o    = |irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      hold_q <= 1'b0;
      pre_q  <= '0;
      mctl_q <= '0;
      cctl_q <= '0;
      act_q  <= '0;
      irq_q  <= '0;
    end else begin
      if (wr_ctrl) {hold_q, en_q} <= bus_wdata_i[1:0];
      if (stop_req) en_q <= 1'b0;
      if (wr_pre)  pre_q  <= bus_wdata_i;
      if (wr_mctl) mctl_q <= bus_wdata_i[MCTL_W-1:0];
      if (wr_cctl) cctl_q <= bus_wdata_i[CCTL_W-1:0];
      if (wr_emr)  act_q  <= bus_wdata_i[NUM_MATCH +: ACT_W];
      irq_q <= (irq_q & ~(wr_irq ? bus_wdata_i[IRQ_W-1:0] : '0)) | irq_set;
    end
  end

  // timer counter: restart beats halt, halt keeps the compare value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tc_q <= '0;
    else if (hold_q)   tc_q <= '0;
    else if (tick) begin
      if (rst_req)       tc_q <= '0;
      else if (!stop_req) tc_q <= tc_q + 1'b1;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      ADDR_W'(A_CTRL): bus_rdata_o[1:0] = {hold_q, en_q};
      ADDR_W'(A_PRE):  bus_rdata_o = pre_q;
      ADDR_W'(A_PCNT): bus_rdata_o = pc;
      ADDR_W'(A_TCNT): bus_rdata_o = tc_q;
      ADDR_W'(A_MCTL): bus_rdata_o[MCTL_W-1:0] = mctl_q;
      ADDR_W'(A_EMR):  bus_rdata_o[NUM_MATCH+ACT_W-1:0] = {act_q, ext_match_o};
      ADDR_W'(A_CCTL): bus_rdata_o[CCTL_W-1:0] = cctl_q;
      ADDR_W'(A_IRQ):  bus_rdata_o[IRQ_W-1:0] = irq_q;
      default: begin
        for (int i = 0; i < NUM_MATCH; i++)
          if (bus_addr_i == ADDR_W'(A_MR_BASE + i)) bus_rdata_o = mr_q[i];
        for (int i = 0; i < NUM_CAP; i++)
          if (bus_addr_i == ADDR_W'(A_CR_BASE + i)) bus_rdata_o = cr[i];
      end
    endcase
  end
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IRQ_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             hold_i,
  input logic             tick_i,
  input logic             rst_req_i,
  input logic             stop_req_i,
  input logic [CNT_W-1:0] tc_i,
  input logic [CNT_W-1:0] pc_i,
  input logic [IRQ_W-1:0] irq_set_i,
  input logic             irq_i
);
  AST_TC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !rst_req_i && !stop_req_i) |=> tc_i == $past(tc_i) + 1'b1); // R1
  AST_PC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> pc_i == '0); // R1
  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (tc_i == '0 && pc_i == '0)); // R2
  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !hold_i) |=> ($stable(tc_i) && $stable(pc_i))); // R2
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && rst_req_i) |=> tc_i == '0); // R3
  AST_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && stop_req_i) |=> !en_i); // R4
  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_set_i) |=> irq_i); // R7
endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W), .IRQ_W(NUM_MATCH + NUM_CAP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_q),
  .hold_i     (hold_q),
  .tick_i     (tick),
  .rst_req_i  (rst_req),
  .stop_req_i (stop_req),
  .tc_i       (tc_q),
  .pc_i       (pc),
  .irq_set_i  (irq_set),
  .irq_i      (irq_o)
);

// File: tb/ptmr_top_tb.sv
module ptmr_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cap = '0;
  logic [3:0]  emo;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] v, t1, t2;
  int unsigned seed_v;

  ptmr_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cap_i(cap),
    .ext_match_o(emo), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 5'(a); wdata = d;
    @(posedge clk); #1; we = 1'b0;
  endtask

  // read without consuming a clock edge; caller stands just after a negedge
  task automatic peek(input int a, output logic [31:0] d);
    addr = 5'(a); #1; d = rdata;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); peek(a, d);
  endtask

  task automatic restart_setup();
    wr(0, 32'h2); wr(1, 0); wr(4, 0); wr(7, 32'hFF);
  endtask

  function automatic int exp_tc(int m, int p);
    return m / (p + 1);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    seed_v = $urandom(777);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8 reset state
    rd(0, v); chk("R8 ctrl", v, 0);
    peek(3, v); chk("R8 tc", v, 0);
    peek(7, v); chk("R8 irq reg", v, 0);
    peek(16, v); chk("R8 capture reg", v, 0);
    chk("R8 irq_o", {31'b0, irq}, 0);
    chk("R8 ext outputs", {28'b0, emo}, 0);

    // R1 prescale, random values
    for (int it = 0; it < 6; it++) begin
      int p, m;
      p = $urandom_range(3, 0);
      m = $urandom_range(40, 1);
      restart_setup(); wr(1, p); wr(0, 1);
      repeat (m) @(posedge clk);
      @(negedge clk);
      peek(3, v); chk("R1 tc", v, exp_tc(m, p));
      peek(2, v); chk("R1 pc", v, m % (p + 1));
    end

    // R2 hold with run set, then frozen when idle
    restart_setup(); wr(0, 3);
    repeat (7) @(posedge clk);
    rd(3, v); chk("R2 held tc", v, 0);
    wr(0, 1); repeat (5) @(posedge clk); wr(0, 0);
    rd(3, t1); chk("R2 tc before freeze", t1, 6);
    repeat (9) @(posedge clk);
    rd(3, v); chk("R2 frozen tc", v, t1);

    // R3/R7 restart on compare, directed edge k=m then random channels
    restart_setup(); wr(8, 4); wr(4, 32'h3); wr(0, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    peek(3, v); chk("R3 tc at value", v, 4);
    peek(7, v); chk("R7 no irq before hit", v, 0);
    @(posedge clk); @(negedge clk);
    peek(3, v); chk("R3 tc restarted", v, 0);
    peek(7, v); chk("R7 irq after hit", v, 1);
    for (int it = 0; it < 5; it++) begin
      int c, m, k;
      c = $urandom_range(3, 0);
      m = $urandom_range(9, 2);
      k = $urandom_range(3 * m, m + 1);
      restart_setup(); wr(8 + c, m); wr(4, 3 << (3 * c)); wr(7, 32'hFF); wr(0, 1);
      repeat (k) @(posedge clk);
      @(negedge clk);
      peek(3, v); chk("R3 periodic tc", v, k % (m + 1));
      peek(7, v); chk("R7 compare irq bit", v, 1 << c);
      chk("R7 irq_o", {31'b0, irq}, 1);
    end
    for (int c = 0; c < 4; c++) wr(8 + c, 32'hFFFF_FFFF);

    // R4 halt on channel 0 (bit 2), prescale 2, value 5
    restart_setup(); wr(1, 2); wr(8, 5); wr(4, 32'h4); wr(0, 1);
    repeat (17) @(posedge clk);
    @(negedge clk);
    peek(0, v); chk("R4 still running", v, 1);
    @(posedge clk); @(negedge clk);
    peek(0, v); chk("R4 run bit cleared", v, 0);
    peek(3, v); chk("R4 tc at value", v, 5);
    peek(2, v); chk("R4 pc zero", v, 0);
    repeat (10) @(posedge clk);
    rd(3, v); chk("R4 stays halted", v, 5);

    // R5 compare outputs: ch0 clear, ch1 set, ch2 toggle, ch3 keep
    restart_setup();
    for (int c = 0; c < 4; c++) wr(8 + c, 3);
    wr(4, 32'h2);
    wr(5, (1 << 4) | (2 << 6) | (3 << 8) | 4'b1001);
    rd(5, v); chk("R5 level readback", v, 32'h399);
    chk("R5 software level", {28'b0, emo}, 4'b1001);
    wr(0, 1);
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R5 first hit", {28'b0, emo}, 4'b1110);
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R5 second hit toggle", {28'b0, emo}, 4'b1010);
    wr(0, 2); wr(5, 0);

    // R6/R7 capture with frozen timer
    restart_setup();
    for (int c = 0; c < 4; c++) wr(8 + c, 32'hFFFF_FFFF);
    wr(6, 32'h5 | 32'h10 | 32'h1C0);
    wr(7, 32'hFF);
    wr(0, 1); repeat ($urandom_range(20, 3)) @(posedge clk); wr(0, 0);
    rd(3, t1);
    @(negedge clk); cap = 4'b0111;
    repeat (3) @(posedge clk); @(negedge clk);
    peek(16, v); chk("R6 rise captured", v, t1);
    peek(17, v); chk("R6 rise ignored on fall-only", v, 0);
    peek(18, v); chk("R6 both-edge rise", v, t1);
    wr(0, 1); repeat ($urandom_range(20, 3)) @(posedge clk); wr(0, 0);
    rd(3, t2);
    @(negedge clk); cap = 4'b1000;
    repeat (3) @(posedge clk); @(negedge clk);
    peek(16, v); chk("R6 fall ignored on rise-only", v, t1);
    peek(17, v); chk("R6 fall captured", v, t2);
    peek(18, v); chk("R6 both-edge fall", v, t2);
    peek(19, v); chk("R6 unconfigured channel", v, 0);
    peek(7, v); chk("R7 capture irq bits", v, 32'h50);
    wr(7, 32'h10); rd(7, v); chk("R7 w1c single bit", v, 32'h40);
    chk("R7 irq_o still high", {31'b0, irq}, 1);
    wr(7, 32'h0); rd(7, v); chk("R7 write zero keeps", v, 32'h40);
    wr(7, 32'h40); rd(7, v); chk("R7 all cleared", v, 0);
    chk("R7 irq_o low", {31'b0, irq}, 0);

    finish_run();
  end
endmodule